// File: doc/BRIEF.md
# Regional Trigger Combiner and Framer

Once per live bunch crossing this block takes in the decision words of one detector region. It accepts a 16-bit word from each of eight track-matching cards and an 8-bit word from each of eight chamber-stub cards. Each word is made of 2-bit counters. Each counter reports how many candidates one card saw for one momentum class, region or quality. The block sums the matching counters from all enabled cards, saturating each sum at 3, to form one 16-bit regional decision.

The decision goes out as a fixed seven-byte frame with a byte-valid strobe, one byte per clock. The frame also carries two error bytes and ends in a parity byte. Seven clocks at the system rate fit inside the shortest crossing period, so a frame normally ends before the next crossing arrives. A crossing that arrives while a frame is still being sent is dropped. The next frame to go out then reports this in its error byte.

The outgoing stream uses valid/ready. The sink may hold `out_ready` low on any cycle, and the block then keeps the same byte on `out_byte` with `out_valid` high. Once a byte is presented it is not withdrawn until it has been accepted. The crossing strobe, the card words, the enable masks and the fault flags are plain inputs. They are sampled only in the cycle in which a crossing is taken.

Top module: `regional_trigger_framer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is low.
- R2: A crossing that is taken makes `out_valid` go high on the next clock. The frame then sends exactly seven bytes, one per valid/ready handshake, in this order: 0xBC, decision bits 7:0, decision bits 15:8, error byte 1, error byte 2, 0x00, parity. `out_valid` does not drop before the seventh byte is accepted.
- R3: Decision field k (bits 2k+1:2k, k = 0..7) is the sum of the following counters, with each card's word taken from the input vectors: field k (bits 2k+1:2k) of each enabled track card, where track card i occupies `trk_words[16i+15:16i]`; and, for k = 4..7 only, field k-4 (bits 2(k-4)+1:2(k-4)) of each enabled chamber card, where chamber card j occupies `chm_words[8j+7:8j]`.
- R4: A card whose bit in `trk_en` or `chm_en` is 0 adds nothing to any field.
- R5: A field whose sum exceeds 3 is sent as 3.
- R6: The parity byte equals the XOR of frame bytes 2 through 6.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` stays unchanged.
- R8: A crossing that arrives while a frame is being sent, in any cycle except the one in which the last byte is accepted, is dropped and starts no frame. The next frame that is sent has error byte 1 bit 0 set. The frame after that has this bit clear, unless another crossing has been dropped in between.
- R9: Error byte 1 is {`fault_in[6:0]`, overrun bit} and error byte 2 is `fault_in[14:7]`, both sampled in the cycle the crossing is taken.
- R10: A crossing in the same cycle as the handshake of the last byte is taken. Its frame starts on the next clock with no idle cycle in between, and its overrun bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xing_valid | input | 1 | One-cycle strobe marking a live crossing |
| trk_words | input | 128 | Eight 16-bit track-card decision words, card i at bits 16i+15:16i |
| chm_words | input | 64 | Eight 8-bit chamber-card decision words, card j at bits 8j+7:8j |
| trk_en | input | 8 | Per-track-card enable mask |
| chm_en | input | 8 | Per-chamber-card enable mask |
| fault_in | input | 15 | Fault flags carried in the error bytes |
| out_ready | input | 1 | Sink accepts the presented byte |
| out_valid | output | 1 | A frame byte is presented |
| out_byte | output | 8 | Frame byte |

## Verification
The assertions assume that traffic starts only after a reset. They do not check crossing inputs outside the taking cycle, because the design ignores them there. They assume `out_ready` may go low on any cycle, and they follow the frame position purely from handshakes. For that reason the stimulus always begins with a reset. It pulses `xing_valid` for exactly one cycle, and changes the card words, masks and faults only at falling edges. It also stalls the sink for several cycles in the middle of a frame. A dropped crossing is placed in the middle of a frame, and a back-to-back crossing exactly on the last handshake, so that both ends of the window in R8 are exercised.

// File: rtl/rtf_pkg.sv
package rtf_pkg;

  localparam int BYTE_W    = 8;
  localparam int FRAME_LEN = 7;

  typedef enum logic [2:0] {
    SLOT_START  = 3'd0,
    SLOT_DEC_LO = 3'd1,
    SLOT_DEC_HI = 3'd2,
    SLOT_ERR1   = 3'd3,
    SLOT_ERR2   = 3'd4,
    SLOT_SPARE  = 3'd5,
    SLOT_PARITY = 3'd6
  } slot_e;

  localparam logic [BYTE_W-1:0] SPARE_BYTE = 8'h00;

endpackage

// File: rtl/rtf_field_sum.sv
module rtf_field_sum #(
  parameter int N_TRK = 8,
  parameter int N_CHM = 8,
  parameter int CNT_W = 2
) (
  input  logic [N_TRK*CNT_W-1:0] trk_cnt,
  input  logic [N_TRK-1:0]       trk_en,
  input  logic [N_CHM*CNT_W-1:0] chm_cnt,
  input  logic [N_CHM-1:0]       chm_en,
  output logic [CNT_W-1:0]       sum
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int SUM_W   = $clog2((N_TRK + N_CHM) * CNT_MAX + 1);
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(CNT_MAX);

  logic [SUM_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N_TRK; i++) begin
      if (trk_en[i]) acc = acc + SUM_W'(trk_cnt[i*CNT_W +: CNT_W]);
    end
    for (int j = 0; j < N_CHM; j++) begin
      if (chm_en[j]) acc = acc + SUM_W'(chm_cnt[j*CNT_W +: CNT_W]);
    end
    sum = (acc > LIMIT) ? CNT_W'(CNT_MAX) : acc[CNT_W-1:0];
  end

endmodule

// File: rtl/rtf_combiner.sv
module rtf_combiner #(
  parameter int N_TRK    = 8,
  parameter int N_CHM    = 8,
  parameter int TRK_W    = 16,
  parameter int CHM_W    = 8,
  parameter int CNT_W    = 2,
  parameter int CHM_BASE = 4
) (
  input  logic [N_TRK*TRK_W-1:0]         trk_words,
  input  logic [N_CHM*CHM_W-1:0]         chm_words,
  input  logic [N_TRK-1:0]               trk_en,
  input  logic [N_CHM-1:0]               chm_en,
  output logic [(TRK_W/CNT_W)*CNT_W-1:0] decision
);
  localparam int TRK_FIELDS = TRK_W / CNT_W;
  localparam int CHM_FIELDS = CHM_W / CNT_W;

  for (genvar k = 0; k < TRK_FIELDS; k++) begin : g_field
    logic [N_TRK*CNT_W-1:0] tf;
    logic [N_CHM*CNT_W-1:0] cf;

    for (genvar i = 0; i < N_TRK; i++) begin : g_trk
      assign tf[i*CNT_W +: CNT_W] = trk_words[i*TRK_W + k*CNT_W +: CNT_W];
    end

    if (k >= CHM_BASE && k < CHM_BASE + CHM_FIELDS) begin : g_has_chm
      for (genvar j = 0; j < N_CHM; j++) begin : g_chm
        assign cf[j*CNT_W +: CNT_W] = chm_words[j*CHM_W + (k-CHM_BASE)*CNT_W +: CNT_W];
      end
    end else begin : g_no_chm
      assign cf = '0;
    end

    rtf_field_sum #(.N_TRK(N_TRK), .N_CHM(N_CHM), .CNT_W(CNT_W)) u_sum (
      .trk_cnt (tf),
      .trk_en  (trk_en),
      .chm_cnt (cf),
      .chm_en  (chm_en),
      .sum     (decision[k*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/rtf_frame_tx.sv
module rtf_frame_tx
  import rtf_pkg::*;
#(
  parameter logic [7:0] START_BYTE = 8'hBC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xing_valid,
  input  logic [15:0] decision,
  input  logic [14:0] fault_in,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [7:0]  out_byte
);
  slot_e      slot_q;
  logic       busy_q;
  logic       ovr_q;
  logic [7:0] dlo_q, dhi_q, e1_q, e2_q, par_q;

  logic       last_hs;
  logic       take;
  logic [7:0] e1_d, e2_d;

  assign last_hs = busy_q && out_ready && (slot_q == SLOT_PARITY);
  assign take    = xing_valid && (!busy_q || last_hs);
  assign e1_d    = {fault_in[6:0], ovr_q};
  assign e2_d    = fault_in[14:7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_START;
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
      dlo_q  <= '0;
      dhi_q  <= '0;
      e1_q   <= '0;
      e2_q   <= '0;
      par_q  <= '0;
    end else if (take) begin
      dlo_q  <= decision[7:0];
      dhi_q  <= decision[15:8];
      e1_q   <= e1_d;
      e2_q   <= e2_d;
      par_q  <= decision[7:0] ^ decision[15:8] ^ e1_d ^ e2_d ^ SPARE_BYTE;
      slot_q <= SLOT_START;
      busy_q <= 1'b1;
      ovr_q  <= 1'b0;
    end else begin
      if (xing_valid) ovr_q <= 1'b1;
      if (busy_q && out_ready) begin
        if (slot_q == SLOT_PARITY) begin
          busy_q <= 1'b0;
          slot_q <= SLOT_START;
        end else begin
          slot_q <= slot_e'(slot_q + 3'd1);
        end
      end
    end
  end

  always_comb begin
    unique case (slot_q)
      SLOT_START:  out_byte = START_BYTE;
      SLOT_DEC_LO: out_byte = dlo_q;
      SLOT_DEC_HI: out_byte = dhi_q;
      SLOT_ERR1:   out_byte = e1_q;
      SLOT_ERR2:   out_byte = e2_q;
      SLOT_SPARE:  out_byte = SPARE_BYTE;
      SLOT_PARITY: out_byte = par_q;
      default:     out_byte = '0;
    endcase
  end

  assign out_valid = busy_q;

endmodule

// File: rtl/regional_trigger_framer.sv
module regional_trigger_framer #(
  parameter int         N_TRK      = 8,
  parameter int         N_CHM      = 8,
  parameter int         TRK_W      = 16,
  parameter int         CHM_W      = 8,
  parameter int         CNT_W      = 2,
  parameter int         CHM_BASE   = 4,
  parameter logic [7:0] START_BYTE = 8'hBC
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xing_valid,
  input  logic [N_TRK*TRK_W-1:0] trk_words,
  input  logic [N_CHM*CHM_W-1:0] chm_words,
  input  logic [N_TRK-1:0]       trk_en,
  input  logic [N_CHM-1:0]       chm_en,
  input  logic [14:0]            fault_in,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [7:0]             out_byte
);
  localparam int DEC_W = (TRK_W / CNT_W) * CNT_W;

  logic [DEC_W-1:0] decision;

  rtf_combiner #(
    .N_TRK(N_TRK), .N_CHM(N_CHM), .TRK_W(TRK_W), .CHM_W(CHM_W),
    .CNT_W(CNT_W), .CHM_BASE(CHM_BASE)
  ) u_comb (
    .trk_words (trk_words),
    .chm_words (chm_words),
    .trk_en    (trk_en),
    .chm_en    (chm_en),
    .decision  (decision)
  );

  rtf_frame_tx #(.START_BYTE(START_BYTE)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .xing_valid (xing_valid),
    .decision   (decision[15:0]),
    .fault_in   (fault_in),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_byte   (out_byte)
  );

endmodule

// File: rtl/regional_trigger_framer_chk.sv
module regional_trigger_framer_chk #(
  parameter logic [7:0] START_BYTE = 8'hBC
) (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte
);
  logic [2:0] pos;
  logic [7:0] run_xor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      run_xor <= '0;
    end else if (out_valid && out_ready) begin
      pos     <= (pos == 3'd6) ? 3'd0 : pos + 3'd1;
      run_xor <= (pos == 3'd0) ? 8'h00 : (run_xor ^ out_byte);
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_start_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pos == 3'd0) |-> out_byte == START_BYTE);

  p_spare_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pos == 3'd5) |-> out_byte == 8'h00);

  p_no_early_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (pos != 3'd6 || !out_ready)) |=> out_valid);

  p_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pos == 3'd6) |-> out_byte == run_xor);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

endmodule

bind regional_trigger_framer regional_trigger_framer_chk #(.START_BYTE(START_BYTE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_byte  (out_byte)
);

// File: tb/tb_regional_trigger_framer.sv
module tb_regional_trigger_framer;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         xing_valid = 1'b0;
  logic [127:0] trk_words = '0;
  logic [63:0]  chm_words = '0;
  logic [7:0]   trk_en = '1;
  logic [7:0]   chm_en = '1;
  logic [14:0]  fault_in = '0;
  logic         out_ready = 1'b1;
  logic         out_valid;
  logic [7:0]   out_byte;

  int checks = 0;
  int fails  = 0;

  logic [7:0]   exp_frame [7];
  logic [127:0] nxt_trk;
  logic [63:0]  nxt_chm;
  logic [7:0]   nxt_te, nxt_ce;
  logic [14:0]  nxt_fault;

  regional_trigger_framer dut (
    .clk(clk), .rst_n(rst_n), .xing_valid(xing_valid),
    .trk_words(trk_words), .chm_words(chm_words),
    .trk_en(trk_en), .chm_en(chm_en), .fault_in(fault_in),
    .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected frame from the requirements (R3, R4, R5, R6, R9)
  task automatic build_exp(input logic [127:0] tw, input logic [63:0] cw,
                           input logic [7:0] te, input logic [7:0] ce,
                           input logic [14:0] fl, input bit ovr);
    logic [15:0] dec;
    dec = '0;
    for (int k = 0; k < 8; k++) begin
      int s = 0;
      for (int i = 0; i < 8; i++) if (te[i]) s += int'(tw[i*16 + k*2 +: 2]);
      if (k >= 4)
        for (int j = 0; j < 8; j++) if (ce[j]) s += int'(cw[j*8 + (k-4)*2 +: 2]);
      dec[k*2 +: 2] = (s > 3) ? 2'd3 : 2'(s);
    end
    exp_frame[0] = 8'hBC;
    exp_frame[1] = dec[7:0];
    exp_frame[2] = dec[15:8];
    exp_frame[3] = {fl[6:0], ovr};
    exp_frame[4] = fl[14:7];
    exp_frame[5] = 8'h00;
    exp_frame[6] = exp_frame[1] ^ exp_frame[2] ^ exp_frame[3] ^ exp_frame[4] ^ exp_frame[5];
  endtask

  task automatic send_crossing(input logic [127:0] tw, input logic [63:0] cw,
                               input logic [7:0] te, input logic [7:0] ce,
                               input logic [14:0] fl, input bit ovr);
    @(negedge clk);
    trk_words = tw; chm_words = cw; trk_en = te; chm_en = ce; fault_in = fl;
    xing_valid = 1'b1;
    build_exp(tw, cw, te, ce, fl, ovr);
  endtask

  task automatic collect(input string tag_dec, input string tag_err,
                         input int stall_at, input int stall_n,
                         input int inject_at, input bit immediate);
    int got = 0;
    int waited = 0;
    int stalled = 0;
    while (got < 7 && waited < 60) begin
      @(negedge clk);
      xing_valid = 1'b0;
      out_ready  = 1'b1;
      if (!out_valid) begin
        if (immediate && got == 0 && waited == 0)
          check(1'b0, "R10", "gap before back-to-back frame", 0, 1);
        waited++;
      end else if (got == stall_at && stalled < stall_n) begin
        out_ready = 1'b0;
        check(out_byte == exp_frame[got], "R7", "byte held under stall",
              out_byte, exp_frame[got]);
        stalled++;
      end else begin
        string req;
        case (got)
          1, 2:    req = tag_dec;
          3, 4:    req = tag_err;
          6:       req = "R6";
          default: req = "R2";
        endcase
        check(out_byte == exp_frame[got], req, $sformatf("frame byte %0d", got),
              out_byte, exp_frame[got]);
        if (got == inject_at) begin
          trk_words = nxt_trk; chm_words = nxt_chm;
          trk_en = nxt_te; chm_en = nxt_ce; fault_in = nxt_fault;
          xing_valid = 1'b1;
        end
        got++;
      end
    end
    if (got < 7) check(1'b0, "R2", "frame incomplete", got, 7);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_basic;
    logic [127:0] tw = '0;
    logic [63:0]  cw = '0;
    tw[1*16 + 0 +: 2] = 2'd1;
    tw[3*16 + 0 +: 2] = 2'd1;
    tw[2*16 + 2 +: 2] = 2'd2;
    tw[5*16 + 4 +: 2] = 2'd1;
    tw[6*16 + 8 +: 2] = 2'd1;
    cw[0*8 + 0 +: 2]  = 2'd1;
    cw[7*8 + 2 +: 2]  = 2'd3;
    tw[4*16 + 12 +: 2] = 2'd1;
    cw[2*8 + 6 +: 2]  = 2'd2;
    send_crossing(tw, cw, 8'hFF, 8'hFF, 15'h5A3C, 1'b0);
    collect("R3", "R9", -1, 0, -1, 1'b0);
  endtask

  task automatic t_saturate;
    send_crossing('1, '1, 8'hFF, 8'hFF, 15'h0001, 1'b0);
    collect("R5", "R9", -1, 0, -1, 1'b0);
    send_crossing({8{16'h5555}}, {8{8'h00}}, 8'h0F, 8'h00, 15'h7FFF, 1'b0);
    collect("R5", "R9", -1, 0, -1, 1'b0);
  endtask

  task automatic t_mask;
    send_crossing({8{16'hFFFF}}, {8{8'hFF}}, 8'b0000_0010, 8'h00, 15'h0000, 1'b0);
    collect("R4", "R9", -1, 0, -1, 1'b0);
    send_crossing({8{16'h5555}}, {8{8'h55}}, 8'h00, 8'b1000_0000, 15'h2222, 1'b0);
    collect("R4", "R9", -1, 0, -1, 1'b0);
  endtask

  task automatic t_backpressure;
    send_crossing({8{16'h1234}}, {8{8'h21}}, 8'b0000_0101, 8'b0001_0000, 15'h1357, 1'b0);
    collect("R3", "R9", 2, 4, -1, 1'b0);
    send_crossing({8{16'h0401}}, {8{8'h10}}, 8'h01, 8'h03, 15'h0F0F, 1'b0);
    collect("R3", "R9", 6, 3, -1, 1'b0);
  endtask

  task automatic t_overrun;
    logic [7:0] saved [7];
    nxt_trk = {8{16'hAAAA}}; nxt_chm = {8{8'hAA}};
    nxt_te = 8'hFF; nxt_ce = 8'hFF; nxt_fault = 15'h7777;
    send_crossing({8{16'h0001}}, '0, 8'h01, 8'h00, 15'h0100, 1'b0);
    collect("R3", "R9", -1, 0, 3, 1'b0);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R8", "dropped crossing started a frame", out_valid, 0);
    end
    send_crossing({8{16'h0040}}, {8{8'h01}}, 8'h03, 8'h01, 15'h0042, 1'b1);
    collect("R3", "R8", -1, 0, -1, 1'b0);
    send_crossing({8{16'h0040}}, {8{8'h01}}, 8'h03, 8'h01, 15'h0042, 1'b0);
    collect("R3", "R8", -1, 0, -1, 1'b0);
    saved = exp_frame;
    check(saved[3][0] == 1'b0, "R8", "overrun bit cleared in model", saved[3][0], 0);
  endtask

  task automatic t_back_to_back;
    nxt_trk = {8{16'h0102}}; nxt_chm = {8{8'h04}};
    nxt_te = 8'hF0; nxt_ce = 8'h0F; nxt_fault = 15'h1111;
    send_crossing({8{16'h2010}}, {8{8'h40}}, 8'h11, 8'h11, 15'h0003, 1'b0);
    collect("R3", "R9", -1, 0, 6, 1'b0);
    build_exp(nxt_trk, nxt_chm, nxt_te, nxt_ce, nxt_fault, 1'b0);
    collect("R10", "R10", -1, 0, -1, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_saturate();
    t_mask();
    t_backpressure();
    t_overrun();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule